// File: doc/BRIEF.md
# Banked Index/Data Configuration Register Block

This block provides a 256-entry configuration register space for legacy plug-and-play logical devices. Software reaches the space through two byte-wide I/O ports. A write to the index port (`io_addr` = 0) chooses a register. A read or write on the data port (`io_addr` = 1) then accesses the chosen register. Registers below index 0x30 are global and shared by all devices. The global register at 0x07 selects the logical device. Every index from 0x30 upward belongs to the bank of the selected device, and each of the `NDEV` devices has its own bank.

The space is protected by a key state machine with three states:
- `ST_LOCKED`: the reset state.
- `ST_KEY_HALF`: one key byte has been seen.
- `ST_OPEN`: writes are accepted.

The transitions are:
- `ST_LOCKED` → `ST_KEY_HALF`: an index write of 0x87.
- `ST_KEY_HALF` → `ST_OPEN`: a second index write of 0x87.
- `ST_KEY_HALF` → `ST_LOCKED`: any other write on either port.
- `ST_OPEN` → `ST_LOCKED`: an index write of 0xAA.

In every other case the state holds.

Each bank drives the following to downstream logic:
- an enable byte;
- a 16-bit I/O base, masked by a fixed per-device mask;
- two interrupt selections with their polarity bits;
- two DMA channel selections.

Writing 0xFFFF to a base and reading it back returns that device's mask. The mask shows the region size and the highest base the region can take.

Top module: `cfg_port_bank`

## Requirements
- R1: While the block is in `ST_OPEN`, an index port write of any value other than 0xAA loads the index. Reading the index port returns the index. The data port reads and writes the register that the index selects.
- R2: Only two consecutive index port writes of 0x87 reach `ST_OPEN`. Any other write between them returns the block to `ST_LOCKED`. An index write of 0xAA in `ST_OPEN` locks the block and leaves the index unchanged. While the block is not open, both ports read 0xFF and writes change no register.
- R3: Global index 0x07 holds the device number and is shared by all devices. Other indices below 0x30 read 0x00 and discard writes. Indices from 0x30 upward are kept separately for each device.
- R4: Index 0x30 holds the 8-bit enable byte of the selected device. The enable byte of device d appears on `dev_en[8d+7:8d]`.
- R5: Index 0x60 holds base bits 15:8 and index 0x61 holds bits 7:0. Each written byte is ANDed with the device's mask. Writing 0xFF to both bytes and reading them back returns the mask. The default masks are 0x07F8, 0x03FC, 0x07F0 and 0x0FF8 for devices 0 to 3. The base of device d appears on `dev_base[16d+15:16d]`.
- R6: With a device number of `NDEV` or more, banked indices read 0xFF and writes to them change no bank.
- R7: Indices 0x70 and 0x72 keep bits 3:0 of the written byte as interrupt numbers 0 and 1. Bits 7:4 read 0. A value of 0 means the source is disabled. The numbers appear on `dev_irq0` and `dev_irq1`, 4 bits per device.
- R8: Indices 0x71 and 0x73 store bit 1 as the polarity of interrupt 0 and interrupt 1. Bit 0 is the type bit and always reads 0, which means edge. All other bits read 0. The polarities appear on `dev_irq_pol` as bit 2d for interrupt 0 and bit 2d+1 for interrupt 1.
- R9: Indices 0x74 and 0x75 keep bits 2:0 of the written byte as DMA channels 0 and 1. The upper bits read 0. The channels appear on `dev_dma0` and `dev_dma1`.
- R10: Reset leaves the block in `ST_LOCKED` with the index, the device number and every banked register at 0. Banked indices that have no register read 0x00. `io_rdata` is 0x00 whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe; gates `io_rdata` |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the current state |
| dev_en | output | NDEV*8 | Enable byte of each device |
| dev_base | output | NDEV*16 | Masked I/O base of each device |
| dev_irq0 | output | NDEV*4 | Interrupt 0 number of each device |
| dev_irq1 | output | NDEV*4 | Interrupt 1 number of each device |
| dev_irq_pol | output | NDEV*2 | Interrupt polarity bits of each device |
| dev_dma0 | output | NDEV*3 | DMA channel 0 of each device |
| dev_dma1 | output | NDEV*3 | DMA channel 1 of each device |

## Verification
The hardest situation to reach from the ports is the half-entered key. A single 0x87 must be followed by an unrelated write, either a data write or another index value, and the block must then stay locked. Random index bytes alone would almost never produce 0x87 twice in a row.

To reach it, the random stimulus draws index values from a short list weighted toward 0x87, 0xAA and the register indices. It also draws device numbers both inside and beyond the populated range. Directed sequences add broken keys, the all-ones mask readback on every device, and writes to a missing device. Every read and every output vector is compared with a model kept in the bench.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int IDX_W = 8;
    localparam int IRQ_W = 4;
    localparam int DMA_W = 3;

    localparam logic [7:0] KEY_OPEN  = 8'h87;
    localparam logic [7:0] KEY_CLOSE = 8'hAA;

    localparam logic [7:0] IX_DEVSEL = 8'h07;
    localparam logic [7:0] IX_BANK0  = 8'h30;
    localparam logic [7:0] IX_ENABLE = 8'h30;
    localparam logic [7:0] IX_BASE_H = 8'h60;
    localparam logic [7:0] IX_BASE_L = 8'h61;
    localparam logic [7:0] IX_IRQ0   = 8'h70;
    localparam logic [7:0] IX_IRQ0_T = 8'h71;
    localparam logic [7:0] IX_IRQ1   = 8'h72;
    localparam logic [7:0] IX_IRQ1_T = 8'h73;
    localparam logic [7:0] IX_DMA0   = 8'h74;
    localparam logic [7:0] IX_DMA1   = 8'h75;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } key_state_t;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_OPEN) state_d = ST_KEY_HALF;
            end
            ST_KEY_HALF: begin
                if (idx_wr && wdata == KEY_OPEN)   state_d = ST_OPEN;
                else if (idx_wr || data_wr)        state_d = ST_LOCKED;
            end
            ST_OPEN: begin
                if (idx_wr && wdata == KEY_CLOSE)  state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (state_q == ST_OPEN);
    end

    AST_CLOSE_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked); // R2
    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_OPEN)); // R2
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_pkg::*;
#(
    parameter logic [15:0] BASE_MASK = 16'h07F8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [7:0]       enable,
    output logic [15:0]      base,
    output logic [IRQ_W-1:0] irq0,
    output logic [IRQ_W-1:0] irq1,
    output logic [1:0]       irq_pol,
    output logic [DMA_W-1:0] dma0,
    output logic [DMA_W-1:0] dma1
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable  <= '0;
            base    <= '0;
            irq0    <= '0;
            irq1    <= '0;
            irq_pol <= '0;
            dma0    <= '0;
            dma1    <= '0;
        end else if (wr_en) begin
            case (idx)
                IX_ENABLE: enable     <= wdata;
                IX_BASE_H: base[15:8] <= wdata & BASE_MASK[15:8];
                IX_BASE_L: base[7:0]  <= wdata & BASE_MASK[7:0];
                IX_IRQ0:   irq0       <= wdata[IRQ_W-1:0];
                IX_IRQ0_T: irq_pol[0] <= wdata[1];
                IX_IRQ1:   irq1       <= wdata[IRQ_W-1:0];
                IX_IRQ1_T: irq_pol[1] <= wdata[1];
                IX_DMA0:   dma0       <= wdata[DMA_W-1:0];
                IX_DMA1:   dma1       <= wdata[DMA_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = 8'h00;
        case (idx)
            IX_ENABLE: rdata = enable;
            IX_BASE_H: rdata = base[15:8];
            IX_BASE_L: rdata = base[7:0];
            IX_IRQ0:   rdata = {{(8-IRQ_W){1'b0}}, irq0};
            IX_IRQ0_T: rdata = {6'b0, irq_pol[0], 1'b0};
            IX_IRQ1:   rdata = {{(8-IRQ_W){1'b0}}, irq1};
            IX_IRQ1_T: rdata = {6'b0, irq_pol[1], 1'b0};
            IX_DMA0:   rdata = {{(8-DMA_W){1'b0}}, dma0};
            IX_DMA1:   rdata = {{(8-DMA_W){1'b0}}, dma1};
            default:   rdata = 8'h00;
        endcase
    end

    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({enable, base, irq0, irq1, irq_pol, dma0, dma1})); // R3
endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank
    import cfg_pkg::*;
#(
    parameter int                  NDEV       = 4,
    parameter logic [NDEV*16-1:0]  BASE_MASKS = 64'h0FF8_07F0_03FC_07F8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic [NDEV*8-1:0]     dev_en,
    output logic [NDEV*16-1:0]    dev_base,
    output logic [NDEV*IRQ_W-1:0] dev_irq0,
    output logic [NDEV*IRQ_W-1:0] dev_irq1,
    output logic [NDEV*2-1:0]     dev_irq_pol,
    output logic [NDEV*DMA_W-1:0] dev_dma0,
    output logic [NDEV*DMA_W-1:0] dev_dma1
);
    localparam logic [7:0] NDEV_B = 8'(NDEV);

    logic            idx_wr, data_wr, unlocked;
    logic [7:0]      idx_q, ldn_q;
    logic [NDEV-1:0] bank_wr;
    logic [7:0]      bank_rd [NDEV];
    logic            in_bank, ldn_ok;
    logic [7:0]      data_val;

    assign idx_wr  = io_wr && !io_addr;
    assign data_wr = io_wr &&  io_addr;
    assign in_bank = (idx_q >= IX_BANK0);
    assign ldn_ok  = (ldn_q < NDEV_B);

    cfg_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .data_wr  (data_wr),
        .wdata    (io_wdata),
        .unlocked (unlocked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ldn_q <= '0;
        end else if (unlocked) begin
            if (idx_wr && io_wdata != KEY_CLOSE) idx_q <= io_wdata;
            if (data_wr && idx_q == IX_DEVSEL)   ldn_q <= io_wdata;
        end
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_bank
        assign bank_wr[d] = data_wr && unlocked && in_bank && (ldn_q == 8'(d));

        cfg_dev_bank #(
            .BASE_MASK (BASE_MASKS[d*16 +: 16])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[d]),
            .idx     (idx_q),
            .wdata   (io_wdata),
            .rdata   (bank_rd[d]),
            .enable  (dev_en[d*8 +: 8]),
            .base    (dev_base[d*16 +: 16]),
            .irq0    (dev_irq0[d*IRQ_W +: IRQ_W]),
            .irq1    (dev_irq1[d*IRQ_W +: IRQ_W]),
            .irq_pol (dev_irq_pol[d*2 +: 2]),
            .dma0    (dev_dma0[d*DMA_W +: DMA_W]),
            .dma1    (dev_dma1[d*DMA_W +: DMA_W])
        );
    end

    always_comb begin
        data_val = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            if (ldn_q == 8'(d)) data_val = bank_rd[d];
        end
        if (!in_bank)    data_val = (idx_q == IX_DEVSEL) ? ldn_q : 8'h00;
        else if (!ldn_ok) data_val = 8'hFF;
    end

    always_comb begin
        if (!io_rd)         io_rdata = 8'h00;
        else if (!unlocked) io_rdata = 8'hFF;
        else if (!io_addr)  io_rdata = idx_q;
        else                io_rdata = data_val;
    end

    AST_LOCKED_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ldn_q)); // R2
    AST_LOCKED_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(idx_q)); // R2
    AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr)); // R3
    AST_NO_BANK_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !ldn_ok |-> (bank_wr == '0)); // R6
endmodule

// File: tb/cfg_port_bank_tb.sv
module cfg_port_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_addr = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [ND*8-1:0]  dev_en;
    logic [ND*16-1:0] dev_base;
    logic [ND*4-1:0]  dev_irq0, dev_irq1;
    logic [ND*2-1:0]  dev_irq_pol;
    logic [ND*3-1:0]  dev_dma0, dev_dma1;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_bank u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_en(dev_en), .dev_base(dev_base),
        .dev_irq0(dev_irq0), .dev_irq1(dev_irq1), .dev_irq_pol(dev_irq_pol),
        .dev_dma0(dev_dma0), .dev_dma1(dev_dma1)
    );

    // bench model
    int         m_st;            // 0 locked, 1 half key, 2 open
    logic [7:0] m_idx, m_ldn;
    logic [7:0] m_en [ND];
    logic [15:0] m_base [ND];
    logic [3:0] m_irq0 [ND], m_irq1 [ND];
    logic [1:0] m_pol [ND];
    logic [2:0] m_dma0 [ND], m_dma1 [ND];

    function automatic logic [15:0] mask_of(int d);
        case (d)
            0: return 16'h07F8;
            1: return 16'h03FC;
            2: return 16'h07F0;
            default: return 16'h0FF8;
        endcase
    endfunction

    function automatic void model_reset();
        m_st = 0; m_idx = 0; m_ldn = 0;
        for (int d = 0; d < ND; d++) begin
            m_en[d] = 0; m_base[d] = 0; m_irq0[d] = 0; m_irq1[d] = 0;
            m_pol[d] = 0; m_dma0[d] = 0; m_dma1[d] = 0;
        end
    endfunction

    function automatic void model_write(logic a, logic [7:0] v);
        int d;
        if (!a) begin
            case (m_st)
                0: if (v == 8'h87) m_st = 1;
                1: m_st = (v == 8'h87) ? 2 : 0;
                default: if (v == 8'hAA) m_st = 0; else m_idx = v;
            endcase
        end else begin
            if (m_st == 1) m_st = 0;
            else if (m_st == 2) begin
                if (m_idx == 8'h07) m_ldn = v;
                else if (m_idx >= 8'h30 && m_ldn < ND) begin
                    d = int'(m_ldn);
                    case (m_idx)
                        8'h30: m_en[d] = v;
                        8'h60: m_base[d][15:8] = v & mask_of(d)[15:8];
                        8'h61: m_base[d][7:0]  = v & mask_of(d)[7:0];
                        8'h70: m_irq0[d] = v[3:0];
                        8'h71: m_pol[d][0] = v[1];
                        8'h72: m_irq1[d] = v[3:0];
                        8'h73: m_pol[d][1] = v[1];
                        8'h74: m_dma0[d] = v[2:0];
                        8'h75: m_dma1[d] = v[2:0];
                        default: ;
                    endcase
                end
            end
        end
    endfunction

    function automatic logic [7:0] model_read(logic a);
        int d;
        if (m_st != 2) return 8'hFF;
        if (!a) return m_idx;
        if (m_idx < 8'h30) return (m_idx == 8'h07) ? m_ldn : 8'h00;
        if (m_ldn >= ND) return 8'hFF;
        d = int'(m_ldn);
        case (m_idx)
            8'h30: return m_en[d];
            8'h60: return m_base[d][15:8];
            8'h61: return m_base[d][7:0];
            8'h70: return {4'h0, m_irq0[d]};
            8'h71: return {6'h0, m_pol[d][0], 1'b0};
            8'h72: return {4'h0, m_irq1[d]};
            8'h73: return {6'h0, m_pol[d][1], 1'b0};
            8'h74: return {5'h0, m_dma0[d]};
            8'h75: return {5'h0, m_dma1[d]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_wdata = v; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(a, v);
    endtask

    task automatic rd(logic a, string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        chk(tag, 64'(io_rdata), 64'(model_read(a)));
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(logic [7:0] ix, logic [7:0] v);
        wr(1'b0, ix); wr(1'b1, v);
    endtask

    task automatic chk_outputs(string tag);
        for (int d = 0; d < ND; d++) begin
            chk({tag, " R4 en"},    64'(dev_en[d*8 +: 8]),     64'(m_en[d]));
            chk({tag, " R5 base"},  64'(dev_base[d*16 +: 16]), 64'(m_base[d]));
            chk({tag, " R7 irq"},   64'({dev_irq1[d*4 +: 4], dev_irq0[d*4 +: 4]}),
                                    64'({m_irq1[d], m_irq0[d]}));
            chk({tag, " R8 pol"},   64'(dev_irq_pol[d*2 +: 2]), 64'(m_pol[d]));
            chk({tag, " R9 dma"},   64'({dev_dma1[d*3 +: 3], dev_dma0[d*3 +: 3]}),
                                    64'({m_dma1[d], m_dma0[d]}));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] pick [12];
        pick = '{8'h87, 8'h87, 8'hAA, 8'h07, 8'h30, 8'h60, 8'h61, 8'h70,
                 8'h71, 8'h73, 8'h74, 8'h05};
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state, locked reads, io_rd gating
        rd(1'b1, "R10 locked data read");
        rd(1'b0, "R10 locked index read");
        @(negedge clk); io_rd = 1'b0; #1;
        chk("R10 rdata idle", 64'(io_rdata), 64'h0);
        chk_outputs("R10 reset");

        // R2: broken key stays locked, write ignored
        wr(1'b0, 8'h87); wr(1'b1, 8'h55); wr(1'b0, 8'h87);
        reg_wr(8'h30, 8'h5A);
        rd(1'b1, "R2 broken key read");
        chk_outputs("R2 broken key");
        wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
        rd(1'b0, "R2 broken by index");

        // R1: unlock and index readback
        wr(1'b0, 8'h87); wr(1'b0, 8'h87);
        wr(1'b0, 8'h3C);
        rd(1'b0, "R1 index readback");

        // R5: all ones readback per device, R3 separation
        for (int d = 0; d < ND; d++) begin
            reg_wr(8'h07, 8'(d));
            reg_wr(8'h60, 8'hFF); wr(1'b1, 8'hFF);
            rd(1'b1, "R5 base high mask");
            wr(1'b0, 8'h61); wr(1'b1, 8'hFF);
            rd(1'b1, "R5 base low mask");
            reg_wr(8'h30, 8'(8'h11 * (d + 1)));
        end
        chk_outputs("R3 banks");
        chk("R5 dev0 mask", 64'(dev_base[15:0]), 64'h07F8);

        // R8: type bit hard-wired
        reg_wr(8'h71, 8'hFF);
        rd(1'b1, "R8 type reads edge");
        // R3: unused global and banked index
        reg_wr(8'h22, 8'h77); rd(1'b1, "R3 global unused");
        reg_wr(8'h90, 8'h77); rd(1'b1, "R10 banked unused");
        // R6: missing device
        reg_wr(8'h07, 8'h05);
        reg_wr(8'h30, 8'h00);
        rd(1'b1, "R6 missing bank read");
        chk_outputs("R6 missing bank");
        // R2: lock with AA keeps index
        wr(1'b0, 8'hAA);
        reg_wr(8'h07, 8'h01);
        wr(1'b0, 8'h87); wr(1'b0, 8'h87);
        rd(1'b0, "R2 index after lock");
        rd(1'b1, "R2 ldn unchanged");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 3) wr(1'b0, pick[$urandom % 12]);
            else if (r < 6) begin
                if (m_idx == 8'h07) wr(1'b1, 8'($urandom % 6));
                else wr(1'b1, 8'($urandom));
            end
            else if (r < 8) rd(1'b1, "R1 random data read");
            else rd(1'b0, "R1 random index read");
            if (i % 100 == 99) chk_outputs("R7 random outputs");
        end
        chk_outputs("R9 final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule